// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models the device side of a 16-bit parallel NOR-style flash. Commands arrive as low bytes on a simple synchronous write bus. A decoder steers reads to one of three views: the storage array, an identification space, or an 8-bit status byte. Two-cycle command pairs start block erase, block lock and block unlock. A setup byte followed by a data write programs one word. A buffered sequence takes a word count, then a short run of data words, then a confirm write, and programs all the words together.

The storage is a small register array divided into equal blocks, each with one lock bit. Program and erase take a fixed number of clock cycles, set by parameters. During that time the block answers every read with its status byte and ignores all writes. Error bits in the status byte are sticky: they stay set until a clear-status command.

Reads are combinational from the address and the current view. A host writes a command and then reads at any address to see the result.

Top module: `pflash_cmd_unit`

## Requirements
- R1: After reset the block is in array view, every word reads 0xFFFF, every block is unlocked, and the status byte reads 0x80.
- R2: Byte 0xFF selects array view and byte 0x90 selects identification view. In identification view, an address with bit 0 clear returns 0x0089 and an address with bit 0 set returns the DEV_CODE parameter.
- R3: Byte 0x70 selects status view, which returns the status byte in the low 8 bits with the upper 8 bits zero. The status byte has ready at bit 7, erase error at bit 5, program error at bit 4 and lock error at bit 1. Bits 6, 3, 2 and 0 always read 0.
- R4: Byte 0x20 followed by confirm byte 0xD0 erases the block that holds the setup address. The erase completes ERASE_CYC cycles after the confirm. Every word of that block then reads 0xFFFF, and the other blocks are unchanged.
- R5: Byte 0x40 followed by a data write programs the word at the data write's address. After PROG_CYC cycles the word holds its old value ANDed with the data.
- R6: While an operation is busy, every read returns the status byte with bit 7 low and all writes are ignored. Bit 7 goes high exactly the stated number of cycles after the starting write.
- R7: Byte 0x60 followed by 0x01 locks the block that holds the setup address. Byte 0x60 followed by 0xD0 unlocks it. Either takes LOCK_CYC cycles.
- R8: A program or erase aimed at a locked block sets bit 1 and also sets bit 4 (program) or bit 5 (erase). It does not go busy and leaves the array unchanged.
- R9: If the second write of a two-cycle command is not a valid confirm byte, bits 5 and 4 are set, the operation is dropped and the array is unchanged.
- R10: Bits 5, 4 and 1 stay set through later commands and later successful operations. Only byte 0x50 clears them. Byte 0x50 does not change the view.
- R11: Byte 0xE8 starts a buffered program. The next write carries the word count minus one in its low byte. That many words follow, each stored at its own address offset within the start address's block. A final 0xD0 programs them all after PROG_CYC cycles. A count field of BUF_DEPTH or more sets bits 5 and 4 and aborts the sequence.
- R12: Every setup byte (0x20, 0x60, 0x40, 0xE8) switches the view to status. Unknown command bytes written while idle are ignored and leave the view unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Word address for reads and writes |
| busWdata | input | 16 | Write data; commands use the low byte |
| busRdata | output | 16 | Read data for the current view and address |

## Verification
A table of command and read pairs walks through the three views. It includes an unknown byte and bad confirm bytes, so that a decoder that ignores bytes correctly can be told apart from one that changes view or corrupts the array. Directed sequences then time each busy window at its last busy cycle and its first ready cycle, which exposes counters that are off by one. Repeated programs of the same word tell AND-programming apart from overwriting. Operations on a locked block, and on the same block after unlocking, separate the lock check from the write path. A successful program made while error bits are set shows that the error bits are sticky rather than cleared by the next operation.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  // command bytes (low byte of a bus write)
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET    = 8'h01;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_WORD_PROG   = 8'h40;
  localparam logic [7:0] CMD_BUF_PROG    = 8'hE8;

  localparam logic [15:0] VENDOR_CODE    = 16'h0089;

  typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STATUS} rdMode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ERA_CFM, SQ_LCK_CFM, SQ_PRG_DATA,
    SQ_BUF_CNT, SQ_BUF_DATA, SQ_BUF_CFM, SQ_BUSY
  } seq_e;

  typedef enum logic [2:0] {OP_ERASE, OP_PROG, OP_BUF, OP_LSET, OP_LCLR} op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doErase;
    logic doProg;
    logic doBufCommit;
    logic doLockSet;
    logic doLockClr;
    logic bufWr;
  } strobe_t;

endpackage

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 4,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 8,
  parameter int LOCK_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  input  logic              qryLocked,
  output logic [ADDR_W-1:0] qryAddr,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [15:0]       opData,
  output logic [$clog2(BUF_DEPTH)-1:0] bufIdx,
  output logic [$clog2(BUF_DEPTH)-1:0] bufLast,
  output rdMode_e           rdMode,
  output logic [7:0]        statusByte,
  output logic              busy
);

  localparam int MAX_EP  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_CYC = (MAX_EP > LOCK_CYC) ? MAX_EP : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IDX_W   = $clog2(BUF_DEPTH);

  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC);
  localparam logic [CNT_W-1:0] LOCK_LD  = CNT_W'(LOCK_CYC);

  seq_e             seq;
  op_e              pend;
  logic [CNT_W-1:0] busCnt;
  logic             errErase, errProg, errLock;
  logic [7:0]       cmd;
  logic             clrHit;

  assign cmd    = busWdata[7:0];
  assign busy   = (seq == SQ_BUSY);
  assign clrHit = busWr && (seq == SQ_IDLE) && (cmd == CMD_CLEAR_STAT);
  assign statusByte = {~busy, 1'b0, errErase, errProg, 1'b0, 1'b0, errLock, 1'b0};
  assign qryAddr = (seq == SQ_PRG_DATA) ? busAddr : opAddr;

  always_comb begin
    strb = '0;
    if (seq == SQ_BUSY && busCnt == CNT_W'(1)) begin
      case (pend)
        OP_ERASE: strb.doErase     = 1'b1;
        OP_PROG:  strb.doProg      = 1'b1;
        OP_BUF:   strb.doBufCommit = 1'b1;
        OP_LSET:  strb.doLockSet   = 1'b1;
        OP_LCLR:  strb.doLockClr   = 1'b1;
        default:  ;
      endcase
    end
    if (seq == SQ_BUF_DATA && busWr) strb.bufWr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq      <= SQ_IDLE;
      pend     <= OP_PROG;
      busCnt   <= '0;
      rdMode   <= RM_ARRAY;
      errErase <= 1'b0;
      errProg  <= 1'b0;
      errLock  <= 1'b0;
      opAddr   <= '0;
      opData   <= '0;
      bufIdx   <= '0;
      bufLast  <= '0;
    end else begin
      case (seq)
        SQ_IDLE: if (busWr) begin
          case (cmd)
            CMD_READ_ARRAY:  rdMode <= RM_ARRAY;
            CMD_READ_ID:     rdMode <= RM_ID;
            CMD_READ_STATUS: rdMode <= RM_STATUS;
            CMD_CLEAR_STAT: begin
              errErase <= 1'b0;
              errProg  <= 1'b0;
              errLock  <= 1'b0;
            end
            CMD_ERASE_SETUP: begin
              seq <= SQ_ERA_CFM; opAddr <= busAddr; rdMode <= RM_STATUS;
            end
            CMD_LOCK_SETUP: begin
              seq <= SQ_LCK_CFM; opAddr <= busAddr; rdMode <= RM_STATUS;
            end
            CMD_WORD_PROG: begin
              seq <= SQ_PRG_DATA; rdMode <= RM_STATUS;
            end
            CMD_BUF_PROG: begin
              seq <= SQ_BUF_CNT; opAddr <= busAddr; rdMode <= RM_STATUS;
            end
            default: ;
          endcase
        end
        SQ_ERA_CFM: if (busWr) begin
          if (cmd == CMD_CONFIRM) begin
            if (qryLocked) begin
              errLock <= 1'b1; errErase <= 1'b1; seq <= SQ_IDLE;
            end else begin
              seq <= SQ_BUSY; pend <= OP_ERASE; busCnt <= ERASE_LD;
            end
          end else begin
            errErase <= 1'b1; errProg <= 1'b1; seq <= SQ_IDLE;
          end
        end
        SQ_LCK_CFM: if (busWr) begin
          if (cmd == CMD_LOCK_SET) begin
            seq <= SQ_BUSY; pend <= OP_LSET; busCnt <= LOCK_LD;
          end else if (cmd == CMD_CONFIRM) begin
            seq <= SQ_BUSY; pend <= OP_LCLR; busCnt <= LOCK_LD;
          end else begin
            errErase <= 1'b1; errProg <= 1'b1; seq <= SQ_IDLE;
          end
        end
        SQ_PRG_DATA: if (busWr) begin
          opAddr <= busAddr;
          opData <= busWdata;
          if (qryLocked) begin
            errLock <= 1'b1; errProg <= 1'b1; seq <= SQ_IDLE;
          end else begin
            seq <= SQ_BUSY; pend <= OP_PROG; busCnt <= PROG_LD;
          end
        end
        SQ_BUF_CNT: if (busWr) begin
          if (int'(cmd) >= BUF_DEPTH) begin
            errErase <= 1'b1; errProg <= 1'b1; seq <= SQ_IDLE;
          end else begin
            bufLast <= cmd[IDX_W-1:0];
            bufIdx  <= '0;
            seq     <= SQ_BUF_DATA;
          end
        end
        SQ_BUF_DATA: if (busWr) begin
          if (bufIdx == bufLast) seq <= SQ_BUF_CFM;
          else bufIdx <= bufIdx + IDX_W'(1);
        end
        SQ_BUF_CFM: if (busWr) begin
          if (cmd == CMD_CONFIRM) begin
            if (qryLocked) begin
              errLock <= 1'b1; errProg <= 1'b1; seq <= SQ_IDLE;
            end else begin
              seq <= SQ_BUSY; pend <= OP_BUF; busCnt <= PROG_LD;
            end
          end else begin
            errErase <= 1'b1; errProg <= 1'b1; seq <= SQ_IDLE;
          end
        end
        SQ_BUSY: begin
          if (busCnt == CNT_W'(1)) begin
            seq    <= SQ_IDLE;
            busCnt <= '0;
          end else begin
            busCnt <= busCnt - CNT_W'(1);
          end
        end
        default: seq <= SQ_IDLE;
      endcase
    end
  end

  // R6: a running operation keeps the sequencer busy until its count ends
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seq == SQ_BUSY && busCnt > CNT_W'(1)) |=> (seq == SQ_BUSY));

  // R6: the busy counter never sits at zero while busy
  p_cnt_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busCnt != '0));

  // R10: error bits only fall on a clear-status write
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clrHit) |=> (({errErase, errProg, errLock} & $past({errErase, errProg, errLock}))
                   == $past({errErase, errProg, errLock})));

endmodule

// File: rtl/pflash_dp.sv
module pflash_dp
  import pflash_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          BLK_W     = 4,
  parameter int          BUF_DEPTH = 4,
  parameter logic [15:0] DEV_CODE  = 16'h0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [15:0]       opData,
  input  logic [$clog2(BUF_DEPTH)-1:0] bufIdx,
  input  logic [$clog2(BUF_DEPTH)-1:0] bufLast,
  input  logic [ADDR_W-1:0] qryAddr,
  output logic              qryLocked,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  input  rdMode_e           rdMode,
  input  logic [7:0]        statusByte,
  input  logic              busy,
  output logic [15:0]       busRdata
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int BKA_W = ADDR_W - BLK_W;
  localparam int NBLK  = 1 << BKA_W;

  logic [15:0]       mem     [WORDS];
  logic [NBLK-1:0]   lockBits;
  logic [ADDR_W-1:0] bufAddr [BUF_DEPTH];
  logic [15:0]       bufData [BUF_DEPTH];
  logic [BKA_W-1:0]  opBlk;

  assign opBlk     = opAddr[ADDR_W-1:BLK_W];
  assign qryLocked = lockBits[qryAddr[ADDR_W-1:BLK_W]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
      for (int j = 0; j < BUF_DEPTH; j++) begin
        bufAddr[j] <= '0;
        bufData[j] <= '0;
      end
      lockBits <= '0;
    end else begin
      if (strb.doErase) begin
        for (int i = 0; i < WORDS; i++)
          if ((i >> BLK_W) == int'(opBlk)) mem[i] <= 16'hFFFF;
      end
      if (strb.doProg) mem[opAddr] <= mem[opAddr] & opData;
      if (strb.doBufCommit) begin
        for (int j = 0; j < BUF_DEPTH; j++)
          if (j <= int'(bufLast)) mem[bufAddr[j]] <= mem[bufAddr[j]] & bufData[j];
      end
      if (strb.bufWr) begin
        bufAddr[bufIdx] <= {opBlk, busAddr[BLK_W-1:0]};
        bufData[bufIdx] <= busWdata;
      end
      if (strb.doLockSet) lockBits[opBlk] <= 1'b1;
      if (strb.doLockClr) lockBits[opBlk] <= 1'b0;
    end
  end

  always_comb begin
    if (busy || rdMode == RM_STATUS) busRdata = {8'h00, statusByte};
    else if (rdMode == RM_ID)        busRdata = busAddr[0] ? DEV_CODE : VENDOR_CODE;
    else                             busRdata = mem[busAddr];
  end

  // R6: a busy block never reports ready on the read port
  p_busy_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busRdata[7] == 1'b0));

  // R8: no erase commit reaches a locked block
  p_erase_unlocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.doErase |-> !lockBits[opBlk]);

  // R8: no word or buffer program commit reaches a locked block
  p_prog_unlocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doProg || strb.doBufCommit) |-> !lockBits[opBlk]);

  // R11: buffer loads stay inside the announced count
  p_buf_index_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWr |-> (bufIdx <= bufLast));

endmodule

// File: rtl/pflash_cmd_unit.sv
module pflash_cmd_unit
  import pflash_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          BLK_W     = 4,
  parameter int          BUF_DEPTH = 4,
  parameter int          ERASE_CYC = 64,
  parameter int          PROG_CYC  = 8,
  parameter int          LOCK_CYC  = 4,
  parameter logic [15:0] DEV_CODE  = 16'h0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata
);

  localparam int IDX_W = $clog2(BUF_DEPTH);

  strobe_t           strb;
  logic [ADDR_W-1:0] opAddr, qryAddr;
  logic [15:0]       opData;
  logic [IDX_W-1:0]  bufIdx, bufLast;
  logic              qryLocked, busy;
  rdMode_e           rdMode;
  logic [7:0]        statusByte;

  pflash_ctrl #(
    .ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .qryLocked(qryLocked), .qryAddr(qryAddr), .strb(strb), .opAddr(opAddr),
    .opData(opData), .bufIdx(bufIdx), .bufLast(bufLast), .rdMode(rdMode),
    .statusByte(statusByte), .busy(busy)
  );

  pflash_dp #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUF_DEPTH(BUF_DEPTH), .DEV_CODE(DEV_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opData(opData),
    .bufIdx(bufIdx), .bufLast(bufLast), .qryAddr(qryAddr), .qryLocked(qryLocked),
    .busAddr(busAddr), .busWdata(busWdata), .rdMode(rdMode),
    .statusByte(statusByte), .busy(busy), .busRdata(busRdata)
  );

endmodule

// File: tb/pflash_cmd_unit_bench.sv
module pflash_cmd_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ERASE_N = 6;
  localparam int PROG_N  = 3;
  localparam int LOCK_N  = 2;
  localparam logic [15:0] DEVC = 16'h1234;
  localparam int NVEC = 27;

  typedef struct packed {
    logic        isWr;
    logic [5:0]  addr;
    logic [15:0] data;   // write data, or expected read value
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 6'h00, 16'hFFFF, 4'd1},   // R1 erased array after reset
    '{1'b0, 6'h25, 16'hFFFF, 4'd1},
    '{1'b1, 6'h00, 16'h0070, 4'd3},
    '{1'b0, 6'h00, 16'h0080, 4'd3},   // R3 clean status byte
    '{1'b1, 6'h00, 16'h0090, 4'd2},
    '{1'b0, 6'h00, 16'h0089, 4'd2},   // R2 vendor code
    '{1'b0, 6'h01, 16'h1234, 4'd2},   // R2 device code
    '{1'b0, 6'h11, 16'h1234, 4'd2},
    '{1'b1, 6'h00, 16'h0033, 4'd12},  // R12 unknown byte
    '{1'b0, 6'h00, 16'h0089, 4'd12},
    '{1'b1, 6'h00, 16'h00FF, 4'd2},
    '{1'b0, 6'h03, 16'hFFFF, 4'd2},
    '{1'b1, 6'h00, 16'h0020, 4'd12},  // R12 setup switches to status
    '{1'b0, 6'h03, 16'h0080, 4'd12},
    '{1'b1, 6'h00, 16'h0055, 4'd9},   // R9 bad erase confirm
    '{1'b0, 6'h00, 16'h00B0, 4'd9},
    '{1'b1, 6'h00, 16'h00FF, 4'd9},
    '{1'b0, 6'h00, 16'hFFFF, 4'd9},
    '{1'b1, 6'h00, 16'h0070, 4'd10},
    '{1'b0, 6'h00, 16'h00B0, 4'd10},  // R10 still set
    '{1'b1, 6'h00, 16'h0050, 4'd10},
    '{1'b0, 6'h00, 16'h0080, 4'd10},
    '{1'b1, 6'h00, 16'h0060, 4'd9},
    '{1'b1, 6'h00, 16'h0077, 4'd9},   // R9 bad lock confirm
    '{1'b0, 6'h00, 16'h00B0, 4'd9},
    '{1'b1, 6'h00, 16'h0050, 4'd10},
    '{1'b0, 6'h00, 16'h0080, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_cmd_unit #(
    .ADDR_W(6), .BLK_W(4), .BUF_DEPTH(4), .ERASE_CYC(ERASE_N),
    .PROG_CYC(PROG_N), .LOCK_CYC(LOCK_N), .DEV_CODE(DEVC)
  ) u_pflash_cmd_unit (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic wrCmd(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [5:0] a, input logic [15:0] exp, input string tag);
    busAddr = a;
    #1;
    nChk++;
    if (busRdata !== exp) begin
      nBad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, busRdata, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // table walk: R1 R2 R3 R9 R10 R12
    for (int k = 0; k < NVEC; k++) begin
      if (VECS[k].isWr) wrCmd(VECS[k].addr, VECS[k].data);
      else begin
        @(negedge clk);
        chk(VECS[k].addr, VECS[k].data, $sformatf("R%0d vec%0d", VECS[k].req, k));
      end
    end

    // R5 R6: single word program and busy window
    wrCmd(6'h05, 16'h0040);
    wrCmd(6'h05, 16'hA5F0);
    chk(6'h05, 16'h0000, "R6 busy after program start");
    idle(PROG_N - 1);
    chk(6'h05, 16'h0000, "R6 last busy cycle");
    idle(1);
    chk(6'h05, 16'h0080, "R6 ready after count");
    wrCmd(6'h00, 16'h00FF);
    chk(6'h05, 16'hA5F0, "R5 programmed word");

    // R5 R6: AND programming, writes while busy ignored
    wrCmd(6'h05, 16'h0040);
    wrCmd(6'h05, 16'h0FFF);
    wrCmd(6'h00, 16'h00FF);
    chk(6'h05, 16'h0000, "R6 still busy");
    idle(1);
    chk(6'h05, 16'h0080, "R6 write during busy ignored");
    wrCmd(6'h00, 16'h00FF);
    chk(6'h05, 16'h05F0, "R5 AND of old and new");

    // R4: erase block 0, block 1 kept
    wrCmd(6'h13, 16'h0040);
    wrCmd(6'h13, 16'h1234);
    idle(PROG_N);
    wrCmd(6'h02, 16'h0020);
    wrCmd(6'h02, 16'h00D0);
    chk(6'h00, 16'h0000, "R4 busy during erase");
    idle(ERASE_N);
    wrCmd(6'h00, 16'h00FF);
    chk(6'h05, 16'hFFFF, "R4 erased word");
    chk(6'h13, 16'h1234, "R4 other block kept");

    // R7 R8: lock block 1, rejected program and erase, then unlock
    wrCmd(6'h10, 16'h0060);
    wrCmd(6'h10, 16'h0001);
    idle(LOCK_N);
    chk(6'h10, 16'h0080, "R7 lock done");
    wrCmd(6'h13, 16'h0040);
    wrCmd(6'h13, 16'h0000);
    chk(6'h13, 16'h0092, "R8 program to locked block");
    wrCmd(6'h00, 16'h00FF);
    chk(6'h13, 16'h1234, "R8 locked word unchanged");
    wrCmd(6'h00, 16'h0050);
    wrCmd(6'h12, 16'h0020);
    wrCmd(6'h12, 16'h00D0);
    chk(6'h12, 16'h00A2, "R8 erase of locked block");
    wrCmd(6'h00, 16'h0050);
    wrCmd(6'h1F, 16'h0060);
    wrCmd(6'h1F, 16'h00D0);
    idle(LOCK_N);
    wrCmd(6'h13, 16'h0040);
    wrCmd(6'h13, 16'h00FF);
    idle(PROG_N);
    wrCmd(6'h00, 16'h00FF);
    chk(6'h13, 16'h0034, "R7 unlocked block programs");

    // R11: buffered program of three words
    wrCmd(6'h20, 16'h00E8);
    wrCmd(6'h20, 16'h0002);
    wrCmd(6'h20, 16'h1111);
    wrCmd(6'h21, 16'h2222);
    wrCmd(6'h22, 16'h3333);
    wrCmd(6'h20, 16'h00D0);
    chk(6'h20, 16'h0000, "R11 busy after buffer confirm");
    idle(PROG_N);
    wrCmd(6'h00, 16'h00FF);
    chk(6'h20, 16'h1111, "R11 word 0");
    chk(6'h21, 16'h2222, "R11 word 1");
    chk(6'h22, 16'h3333, "R11 word 2");
    @(negedge clk);
    chk(6'h23, 16'hFFFF, "R11 neighbour untouched");
    wrCmd(6'h20, 16'h00E8);
    wrCmd(6'h20, 16'h0004);
    chk(6'h20, 16'h00B0, "R11 count too large");
    wrCmd(6'h00, 16'h0050);

    // R10: errors survive a successful operation
    wrCmd(6'h00, 16'h0020);
    wrCmd(6'h00, 16'h00FF);
    wrCmd(6'h30, 16'h0040);
    wrCmd(6'h30, 16'h00F0);
    idle(PROG_N);
    chk(6'h30, 16'h00B0, "R10 sticky across success");
    wrCmd(6'h00, 16'h00FF);
    chk(6'h30, 16'h00F0, "R10 op still completed");
    wrCmd(6'h00, 16'h0050);
    wrCmd(6'h00, 16'h0070);
    chk(6'h00, 16'h0080, "R10 cleared");

    // R1: reset in mid-run restores the erased array and view
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
    chk(6'h13, 16'hFFFF, "R1 array after reset");
    wrCmd(6'h00, 16'h0070);
    chk(6'h00, 16'h0080, "R1 status after reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule